// File: doc/BRIEF.md
# Privilege-Banked Vector State Swapper

This block keeps the live vector-context word that the vector unit consumes, plus one banked shadow word for each of the three privilege levels (user, supervisor, machine). A trap into a level exchanges the live word with that level's shadow. The matching trap return performs the same exchange again. Because the operation is a swap and not a one-way copy, nested traps unwind without any software save: each handler sees its own context, and the interrupted one comes back untouched.

A small register port lets software read and write the live word and the shadows. Every shadow access is checked against the current privilege level. A refused access raises a one-cycle flag, changes nothing and reads as zero. Privilege codes are user `2'b00`, supervisor `2'b01` and machine `2'b11`. The code `2'b10` is reserved.

Top module: `vstate_bank`

## Requirements
- R1: Synchronous active-high reset clears the live word and all three shadows to zero, and it also clears `csr_rdata` and `csr_illegal`.
- R2: A trap-entry strobe with a valid target level exchanges the live word and that level's shadow in one clock edge.
- R3: A trap-return strobe with a valid level exchanges the live word and that level's shadow again in one clock edge.
- R4: A machine trap taken inside a user trap handler and then returned leaves the handler's live word as it was. The later user return restores the original live word.
- R5: Selector `csr_sel` is 0 for the live word, 1 for the user shadow, 2 for the supervisor shadow and 3 for the machine shadow. The live word is open to every level. Machine may access all shadows. Supervisor may access the user and supervisor shadows. User may access no shadow.
- R6: A refused access sets `csr_illegal` for exactly the following cycle, modifies no register and returns zero on `csr_rdata`.
- R7: An accepted read presents, on the cycle after the request, the value the register held before that clock edge.
- R8: Entry and return strobes in the same cycle act as the return swap followed by the entry swap.
- R9: A register write in a cycle that also performs a swap is dropped, even when it targets a register the swap does not touch.
- R10: A strobe that carries the reserved level code `2'b10` has no effect. A reserved current-privilege code is treated as user.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_priv | input | 2 | Current privilege level of the requester |
| trap_enter | input | 1 | Trap-entry strobe |
| enter_lvl | input | 2 | Level being entered |
| trap_ret | input | 1 | Trap-return strobe |
| ret_lvl | input | 2 | Level being left |
| csr_en | input | 1 | Register access request |
| csr_we | input | 1 | Request is a write |
| csr_sel | input | 2 | Register selector |
| csr_wdata | input | W | Write data |
| csr_rdata | output | W | Read data, one cycle after the request |
| csr_illegal | output | 1 | Refused-access pulse, one cycle after the request |
| live_state | output | W | Current live vector-context word |

## Verification
The hardest case to reach is a three-deep sequence: a user trap, a write by the handler, a machine trap on top, the machine return and then the user return. Only that sequence shows that each swap restores exactly what the level below it left. The bench first loads distinct marker values into every register from machine mode. It then walks the sequence one strobe per cycle and reads `live_state` after each step. Same-cycle return-plus-entry and swap-versus-write collisions are driven in a single cycle. Each is followed by machine-mode reads that expose all four registers.

// File: rtl/vstate_pkg.sv
package vstate_pkg;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'b00,
        PRIV_SUPER = 2'b01,
        PRIV_RSVD  = 2'b10,
        PRIV_MACH  = 2'b11
    } priv_t;

    typedef enum logic [1:0] {
        SEL_LIVE    = 2'd0,
        SEL_SH_USER = 2'd1,
        SEL_SH_SUP  = 2'd2,
        SEL_SH_MACH = 2'd3
    } csr_sel_t;

    localparam int NUM_LVL = 3;

    function automatic logic lvl_valid(input logic [1:0] lvl);
        return lvl != PRIV_RSVD;
    endfunction

    // shadow slot: user 0, supervisor 1, machine 2
    function automatic logic [1:0] lvl_slot(input logic [1:0] lvl);
        logic [1:0] r;
        case (lvl)
            PRIV_SUPER: r = 2'd1;
            PRIV_MACH:  r = 2'd2;
            default:    r = 2'd0;
        endcase
        return r;
    endfunction

    function automatic logic access_ok(input logic [1:0] priv, input logic [1:0] sel);
        logic ok;
        if (sel == SEL_LIVE)          ok = 1'b1;
        else if (priv == PRIV_MACH)   ok = 1'b1;
        else if (priv == PRIV_SUPER)  ok = (sel != SEL_SH_MACH);
        else                          ok = 1'b0;
        return ok;
    endfunction

endpackage

// File: rtl/vstate_swap_net.sv
module vstate_swap_net
    import vstate_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]              live_i,
    input  logic [NUM_LVL-1:0][W-1:0] sh_i,
    input  logic                      enter_i,
    input  logic [1:0]                enter_lvl_i,
    input  logic                      ret_i,
    input  logic [1:0]                ret_lvl_i,
    output logic [W-1:0]              live_o,
    output logic [NUM_LVL-1:0][W-1:0] sh_o,
    output logic                      swap_o
);
    logic ret_go, ent_go;
    logic [W-1:0] tmp;

    assign ret_go = ret_i   && lvl_valid(ret_lvl_i);
    assign ent_go = enter_i && lvl_valid(enter_lvl_i);
    assign swap_o = ret_go || ent_go;

    always_comb begin
        live_o = live_i;
        sh_o   = sh_i;
        tmp    = '0;
        // return is applied first, then entry
        if (ret_go) begin
            tmp                     = live_o;
            live_o                  = sh_o[lvl_slot(ret_lvl_i)];
            sh_o[lvl_slot(ret_lvl_i)] = tmp;
        end
        if (ent_go) begin
            tmp                       = live_o;
            live_o                    = sh_o[lvl_slot(enter_lvl_i)];
            sh_o[lvl_slot(enter_lvl_i)] = tmp;
        end
    end
endmodule

// File: rtl/vstate_csr_port.sv
module vstate_csr_port
    import vstate_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [1:0]                cur_priv,
    input  logic                      csr_en,
    input  logic                      csr_we,
    input  logic [1:0]                csr_sel,
    input  logic [W-1:0]              live_i,
    input  logic [NUM_LVL-1:0][W-1:0] sh_i,
    output logic                      wr_ok_o,
    output logic                      refused_o,
    output logic [W-1:0]              rdata_o,
    output logic                      illegal_o
);
    logic         legal;
    logic [W-1:0] rd_mux;

    assign legal     = access_ok(cur_priv, csr_sel);
    assign wr_ok_o   = csr_en && csr_we && legal;
    assign refused_o = csr_en && !legal;

    always_comb begin
        case (csr_sel)
            SEL_SH_USER: rd_mux = sh_i[0];
            SEL_SH_SUP:  rd_mux = sh_i[1];
            SEL_SH_MACH: rd_mux = sh_i[2];
            default:     rd_mux = live_i;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o   <= '0;
            illegal_o <= 1'b0;
        end else begin
            illegal_o <= refused_o;
            rdata_o   <= (csr_en && legal) ? rd_mux : '0;
        end
    end

    assert_refused_zero_R6: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (rdata_o == '0));

    assert_user_no_shadow_R5: assert property (@(posedge clk) disable iff (rst)
        (csr_en && cur_priv == PRIV_USER && csr_sel != SEL_LIVE) |=> illegal_o);
endmodule

// File: rtl/vstate_bank.sv
module vstate_bank
    import vstate_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   cur_priv,
    input  logic         trap_enter,
    input  logic [1:0]   enter_lvl,
    input  logic         trap_ret,
    input  logic [1:0]   ret_lvl,
    input  logic         csr_en,
    input  logic         csr_we,
    input  logic [1:0]   csr_sel,
    input  logic [W-1:0] csr_wdata,
    output logic [W-1:0] csr_rdata,
    output logic         csr_illegal,
    output logic [W-1:0] live_state
);
    logic [W-1:0]              live_q, live_sw;
    logic [NUM_LVL-1:0][W-1:0] sh_q, sh_sw;
    logic                      swap_any, wr_ok, refused;

    vstate_swap_net #(.W(W)) u_swap (
        .live_i(live_q), .sh_i(sh_q),
        .enter_i(trap_enter), .enter_lvl_i(enter_lvl),
        .ret_i(trap_ret), .ret_lvl_i(ret_lvl),
        .live_o(live_sw), .sh_o(sh_sw), .swap_o(swap_any)
    );

    vstate_csr_port #(.W(W)) u_port (
        .clk(clk), .rst(rst), .cur_priv(cur_priv),
        .csr_en(csr_en), .csr_we(csr_we), .csr_sel(csr_sel),
        .live_i(live_q), .sh_i(sh_q),
        .wr_ok_o(wr_ok), .refused_o(refused),
        .rdata_o(csr_rdata), .illegal_o(csr_illegal)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
            sh_q   <= '0;
        end else if (swap_any) begin
            live_q <= live_sw;
            sh_q   <= sh_sw;
        end else if (wr_ok) begin
            if (csr_sel == SEL_LIVE) live_q <= csr_wdata;
            else                     sh_q[csr_sel - 2'd1] <= csr_wdata;
        end
    end

    assign live_state = live_q;

    assert_entry_swap_R2: assert property (@(posedge clk) disable iff (rst)
        (trap_enter && lvl_valid(enter_lvl) && !trap_ret) |=>
        (live_q == $past(sh_q[lvl_slot(enter_lvl)]) &&
         sh_q[$past(lvl_slot(enter_lvl))] == $past(live_q)));

    assert_return_swap_R3: assert property (@(posedge clk) disable iff (rst)
        (trap_ret && lvl_valid(ret_lvl) && !trap_enter) |=>
        (live_q == $past(sh_q[lvl_slot(ret_lvl)]) &&
         sh_q[$past(lvl_slot(ret_lvl))] == $past(live_q)));

    assert_refused_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (refused && !trap_enter && !trap_ret) |=>
        (live_q == $past(live_q) && sh_q == $past(sh_q)));

    assert_write_dropped_R9: assert property (@(posedge clk) disable iff (rst)
        (csr_en && csr_we && csr_sel == SEL_SH_SUP && trap_enter &&
         enter_lvl == PRIV_USER && !trap_ret) |=> $stable(sh_q[1]));

    assert_rsvd_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (trap_enter && enter_lvl == PRIV_RSVD && !trap_ret && !csr_en) |=>
        (live_q == $past(live_q) && sh_q == $past(sh_q)));
endmodule

// File: tb/vstate_bank_bench.sv
module vstate_bank_bench;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   cur_priv = 2'b11;
    logic         trap_enter = 1'b0, trap_ret = 1'b0;
    logic [1:0]   enter_lvl = 2'b00, ret_lvl = 2'b00;
    logic         csr_en = 1'b0, csr_we = 1'b0;
    logic [1:0]   csr_sel = 2'd0;
    logic [W-1:0] csr_wdata = '0;
    logic [W-1:0] csr_rdata, live_state;
    logic         csr_illegal;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [W-1:0] rd_v;
    logic         ill_v;

    localparam logic [1:0] PU = 2'b00, PS = 2'b01, PR = 2'b10, PM = 2'b11;

    always #10 clk = ~clk;

    vstate_bank #(.W(W)) u_vstate_bank (
        .clk(clk), .rst(rst), .cur_priv(cur_priv),
        .trap_enter(trap_enter), .enter_lvl(enter_lvl),
        .trap_ret(trap_ret), .ret_lvl(ret_lvl),
        .csr_en(csr_en), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .csr_illegal(csr_illegal), .live_state(live_state)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: drive, take the edge, sample just after, release
    task automatic cyc(input logic en, input logic we, input logic [1:0] pv,
                       input logic [1:0] sel, input logic [W-1:0] wd,
                       input logic ent, input logic [1:0] el,
                       input logic rt, input logic [1:0] rl);
        cur_priv = pv; csr_en = en; csr_we = we; csr_sel = sel; csr_wdata = wd;
        trap_enter = ent; enter_lvl = el; trap_ret = rt; ret_lvl = rl;
        @(posedge clk); #1;
        rd_v = csr_rdata; ill_v = csr_illegal;
        csr_en = 0; csr_we = 0; trap_enter = 0; trap_ret = 0;
    endtask

    task automatic wr(input logic [1:0] pv, input logic [1:0] sel, input logic [W-1:0] d);
        cyc(1, 1, pv, sel, d, 0, PU, 0, PU);
    endtask
    task automatic rd(input logic [1:0] pv, input logic [1:0] sel);
        cyc(1, 0, pv, sel, '0, 0, PU, 0, PU);
    endtask
    task automatic enter(input logic [1:0] l); cyc(0, 0, PM, 0, '0, 1, l, 0, PU); endtask
    task automatic leave(input logic [1:0] l); cyc(0, 0, PM, 0, '0, 0, PU, 1, l); endtask

    task automatic load_all(input logic [W-1:0] lv, input logic [W-1:0] u,
                            input logic [W-1:0] s, input logic [W-1:0] m);
        wr(PM, 0, lv); wr(PM, 1, u); wr(PM, 2, s); wr(PM, 3, m);
    endtask

    task automatic expect_reg(input string req, input logic [1:0] sel, input logic [W-1:0] exp);
        rd(PM, sel);
        chk(req, rd_v, exp);
    endtask

    task automatic t_reset;
        chk("R1 live", live_state, '0);
        chk("R1 rdata", csr_rdata, '0);
        chk("R1 illegal", {31'b0, csr_illegal}, 0);
        for (int i = 1; i < 4; i++) expect_reg("R1 shadow", i[1:0], '0);
    endtask

    task automatic t_access_readback;
        load_all(32'hA0, 32'hB1, 32'hC2, 32'hD3);
        expect_reg("R7 live", 0, 32'hA0);
        expect_reg("R7 ush", 1, 32'hB1);
        expect_reg("R7 ssh", 2, 32'hC2);
        expect_reg("R7 msh", 3, 32'hD3);
        // read and write in one request: old value returned
        cyc(1, 1, PM, 0, 32'hEE, 0, PU, 0, PU);
        chk("R7 pre-edge value", rd_v, 32'hA0);
        chk("R7 write landed", live_state, 32'hEE);
    endtask

    task automatic t_entry_return;
        load_all(32'h111, 32'h222, 32'h333, 32'h444);
        enter(PS);
        chk("R2 live after S entry", live_state, 32'h333);
        expect_reg("R2 ssh after entry", 2, 32'h111);
        leave(PS);
        chk("R3 live after S return", live_state, 32'h111);
        expect_reg("R3 ssh after return", 2, 32'h333);
    endtask

    task automatic t_nested;
        load_all(32'hAAAA, 32'hBBBB, 32'h0, 32'hDDDD);
        enter(PU);
        chk("R2 U entry", live_state, 32'hBBBB);
        wr(PU, 0, 32'hCCCC);
        chk("R5 user writes live", live_state, 32'hCCCC);
        enter(PM);
        chk("R4 M entry", live_state, 32'hDDDD);
        leave(PM);
        chk("R4 U handler resumes", live_state, 32'hCCCC);
        leave(PU);
        chk("R4 app restored", live_state, 32'hAAAA);
        expect_reg("R4 ush keeps handler", 1, 32'hCCCC);
        expect_reg("R4 msh back", 3, 32'hDDDD);
    endtask

    task automatic t_refusals;
        load_all(32'h10, 32'h20, 32'h30, 32'h40);
        for (int s = 1; s < 4; s++) begin
            cyc(1, 1, PU, s[1:0], 32'hFFFF, 0, PU, 0, PU);
            chk("R6 user refused flag", {31'b0, ill_v}, 1);
            chk("R6 user refused rdata", rd_v, '0);
        end
        rd(PU, 0);
        chk("R6 flag lasts one cycle", {31'b0, ill_v}, 0);
        chk("R5 user reads live", rd_v, 32'h10);
        cyc(1, 1, PS, 3, 32'hFFFF, 0, PU, 0, PU);
        chk("R5 super refused on msh", {31'b0, ill_v}, 1);
        cyc(1, 0, PR, 2, '0, 0, PU, 0, PU);
        chk("R10 reserved priv treated as user", {31'b0, ill_v}, 1);
        expect_reg("R6 ush untouched", 1, 32'h20);
        expect_reg("R6 ssh untouched", 2, 32'h30);
        expect_reg("R6 msh untouched", 3, 32'h40);
        wr(PS, 1, 32'h21);
        chk("R5 super write ush ok", {31'b0, ill_v}, 0);
        rd(PS, 2);
        chk("R5 super reads ssh", rd_v, 32'h30);
        expect_reg("R5 ush written by super", 1, 32'h21);
    endtask

    task automatic t_same_cycle;
        load_all(32'h1, 32'h2, 32'h3, 32'h4);
        cyc(0, 0, PM, 0, '0, 1, PM, 1, PS);
        chk("R8 live", live_state, 32'h4);
        expect_reg("R8 ssh", 2, 32'h1);
        expect_reg("R8 msh", 3, 32'h3);
        expect_reg("R8 ush", 1, 32'h2);
    endtask

    task automatic t_swap_beats_write;
        load_all(32'h55, 32'h66, 32'h77, 32'h88);
        cyc(1, 1, PM, 0, 32'h99, 1, PU, 0, PU);
        chk("R9 live from swap", live_state, 32'h66);
        expect_reg("R9 ush", 1, 32'h55);
        cyc(1, 1, PM, 2, 32'h99, 0, PU, 1, PU);
        chk("R9 live after return", live_state, 32'h55);
        expect_reg("R9 ssh write dropped", 2, 32'h77);
    endtask

    task automatic t_reserved;
        load_all(32'h5A, 32'h6B, 32'h7C, 32'h8D);
        enter(PR);
        chk("R10 reserved entry", live_state, 32'h5A);
        leave(PR);
        chk("R10 reserved return", live_state, 32'h5A);
        expect_reg("R10 ush", 1, 32'h6B);
        expect_reg("R10 ssh", 2, 32'h7C);
        expect_reg("R10 msh", 3, 32'h8D);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset;
        t_access_readback;
        t_entry_return;
        t_nested;
        t_refusals;
        t_same_cycle;
        t_swap_beats_write;
        t_reserved;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule